// File: doc/BRIEF.md
# Multi-Instance Primitive Sequence Detector

This block sits on the receive side of a serial storage link, after character decoding. Each cycle it may accept one 32-bit dword together with a flag saying that the dword's first character is a control character. It recognises primitives by comparing the whole dword against a small programmable table. Each table entry assigns a class, and the class decides how many back-to-back copies must arrive before the primitive is accepted.

Primitives that need several copies follow simple rules. A run of identical copies builds a count, and any unrelated dword breaks the run. Clock-compensation filler, and for some classes notification filler, may sit between copies without breaking the run. When the count reaches the class threshold, the block raises a one-cycle valid strobe carrying the table index of the primitive. A run that keeps going after that raises no further strobe.

Top module: `prim_seq_detect`

## Requirements
- R1: After reset `primValid` is 0 and `primCode` is 0, and no run is in progress.
- R2: A dword counts as a primitive only when `ctrlIn` is 1 and bits [7:0] equal 8'hBC, 8'h7C or 8'hDC, and all 32 bits equal a table entry whose class is reportable or filler. Any other dword is treated as data.
- R3: A write with `cfgWe` high stores `cfgValue` and `cfgClass` into entry `cfgIdx`, and the entry is used from the next cycle on. When two entries hold the same value, the lower index wins. Class codes: 0 unused, 1 single, 2 repeated, 3 triple, 4 redundant, 5 clock-compensation filler, 6 notify filler, 7 unused.
- R4: A single-class primitive is accepted on its first instance.
- R5: A repeated-class primitive is accepted after `REP_NEED` consecutive identical instances (default 2). Filler of either kind breaks the run.
- R6: A triple-class primitive is accepted after 3 consecutive identical instances. Class 5 and class 6 dwords between instances leave the count unchanged.
- R7: A redundant-class primitive is accepted after `RED_NEED` consecutive identical instances (default 3). Class 5 dwords between instances leave the count unchanged, and a class 6 dword breaks the run.
- R8: Any other accepted dword breaks the current run. This covers data, an unmatched primitive, a different primitive and filler that is not permitted. A different reportable primitive starts a new run with a count of 1.
- R9: Once a run has produced its strobe, further identical instances produce none until the run is broken.
- R10: Cycles with `inValid` low change nothing and produce no strobe.
- R11: `primValid` is high for exactly the cycle after the clock edge that accepted the completing dword. `primCode` then shows that primitive's table index and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Table entry write strobe |
| cfgIdx | input | $clog2(TBL_DEPTH) | Table entry written |
| cfgValue | input | 32 | Dword value for the entry |
| cfgClass | input | 3 | Class code for the entry |
| inValid | input | 1 | Received dword present this cycle |
| dwordIn | input | 32 | Received dword, first character in bits [7:0] |
| ctrlIn | input | 1 | First character is a control character |
| primValid | output | 1 | One-cycle acceptance strobe |
| primCode | output | $clog2(TBL_DEPTH) | Table index of the accepted primitive |

## Verification
The bench targets filler handling, because it differs by class. If triple and redundant runs shared one rule, a notify dword inside a redundant run would wrongly lead to a strobe. If filler did not hold the count, a triple run with filler between its copies would never be accepted.

Two further cases catch a missing re-arm guard and a run counter that ignores gap cycles. Without the guard, a long run would emit one strobe per copy. A counter that ignores gaps would either lose runs that have idle cycles between copies, or count those idle cycles as copies.

The bench also covers duplicate table entries, which show whether the lowest index takes priority. It covers primitives with the right value but no control flag, which show that the flag is required.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_SINGLE = 3'd1,
    CLS_REPEAT = 3'd2,
    CLS_TRIPLE = 3'd3,
    CLS_REDUND = 3'd4,
    CLS_ALIGN  = 3'd5,
    CLS_NOTIFY = 3'd6,
    CLS_RSVD   = 3'd7
  } primClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCand;
    logic fire;
  } runStrobe_t;

  localparam logic [7:0] KCHAR_SAS  = 8'hBC;
  localparam logic [7:0] KCHAR_SATA = 8'h7C;
  localparam logic [7:0] KCHAR_ERR  = 8'hDC;

  function automatic logic isReportable(primClass_t c);
    return (c == CLS_SINGLE) || (c == CLS_REPEAT) ||
           (c == CLS_TRIPLE) || (c == CLS_REDUND);
  endfunction

  function automatic logic isFiller(primClass_t c);
    return (c == CLS_ALIGN) || (c == CLS_NOTIFY);
  endfunction

endpackage

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [31:0]      cfgValue,
  input  logic [2:0]       cfgClass,
  input  logic [31:0]      dwordIn,
  input  logic             ctrlIn,
  input  runStrobe_t       stb,
  output logic             isPrim,
  output primClass_t       hitClass,
  output logic             matchCand,
  output logic [IDX_W-1:0] primCode
);

  logic [31:0]      tblVal [TBL_DEPTH];
  primClass_t       tblCls [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] entryHit;
  logic             anyHit;
  logic [IDX_W-1:0] hitIdx;
  primClass_t       hitCls;
  logic             kOk;
  logic [31:0]      candValue;

  // table storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        tblVal[i] <= '0;
        tblCls[i] <= CLS_NONE;
      end
    end else if (cfgWe) begin
      tblVal[cfgIdx] <= cfgValue;
      tblCls[cfgIdx] <= primClass_t'(cfgClass);
    end
  end

  // per-entry comparators
  for (genvar g = 0; g < TBL_DEPTH; g++) begin : gEntry
    assign entryHit[g] = (dwordIn == tblVal[g]) &&
                         (isReportable(tblCls[g]) || isFiller(tblCls[g]));
  end

  // lowest index wins
  always_comb begin
    hitIdx = '0;
    hitCls = CLS_NONE;
    for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
      if (entryHit[i]) begin
        hitIdx = IDX_W'(i);
        hitCls = tblCls[i];
      end
    end
  end

  assign anyHit = |entryHit;
  assign kOk    = (dwordIn[7:0] == KCHAR_SAS) || (dwordIn[7:0] == KCHAR_SATA) ||
                  (dwordIn[7:0] == KCHAR_ERR);
  assign isPrim    = ctrlIn && kOk && anyHit;
  assign hitClass  = isPrim ? hitCls : CLS_NONE;
  assign matchCand = isPrim && (dwordIn == candValue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candValue <= '0;
      primCode  <= '0;
    end else begin
      if (stb.loadCand) candValue <= dwordIn;
      if (stb.fire)     primCode  <= hitIdx;
    end
  end

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.fire |=> $stable(primCode)); // R11

  AST_FIRE_ON_PRIM: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> isPrim); // R2

endmodule

// File: rtl/pdt_control.sv
module pdt_control
  import pdt_pkg::*;
#(
  parameter int REP_NEED = 2,
  parameter int RED_NEED = 3,
  localparam int TRI_NEED = 3,
  localparam int MAX_A    = (REP_NEED > TRI_NEED) ? REP_NEED : TRI_NEED,
  localparam int MAX_NEED = (MAX_A > RED_NEED) ? MAX_A : RED_NEED,
  localparam int CNT_W    = $clog2(MAX_NEED + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isPrim,
  input  primClass_t hitClass,
  input  logic       matchCand,
  output runStrobe_t stb,
  output logic       primValid
);

  logic             candActive, nxtActive;
  primClass_t       candClass, nxtClass;
  logic [CNT_W-1:0] runCount, nxtCount;
  logic             fired, nxtFired;
  logic             fillHold;

  function automatic int needOf(primClass_t c);
    case (c)
      CLS_SINGLE: return 1;
      CLS_REPEAT: return REP_NEED;
      CLS_TRIPLE: return TRI_NEED;
      CLS_REDUND: return RED_NEED;
      default:    return MAX_NEED + 1;
    endcase
  endfunction

  // filler tolerated inside the current run
  always_comb begin
    fillHold = 1'b0;
    if (candActive && isPrim && !matchCand) begin
      if (hitClass == CLS_ALIGN)
        fillHold = (candClass == CLS_TRIPLE) || (candClass == CLS_REDUND);
      else if (hitClass == CLS_NOTIFY)
        fillHold = (candClass == CLS_TRIPLE);
    end
  end

  always_comb begin
    nxtActive = candActive;
    nxtClass  = candClass;
    nxtCount  = runCount;
    nxtFired  = fired;
    stb       = '0;
    if (inValid) begin
      if (candActive && matchCand) begin
        if (int'(runCount) < MAX_NEED) nxtCount = runCount + CNT_W'(1);
        if (!fired && int'(nxtCount) >= needOf(candClass)) begin
          stb.fire = 1'b1;
          nxtFired = 1'b1;
        end
      end else if (fillHold) begin
        // run continues unchanged
      end else if (isPrim && isReportable(hitClass)) begin
        stb.loadCand = 1'b1;
        nxtActive    = 1'b1;
        nxtClass     = hitClass;
        nxtCount     = CNT_W'(1);
        nxtFired     = (needOf(hitClass) == 1);
        stb.fire     = (needOf(hitClass) == 1);
      end else begin
        nxtActive = 1'b0;
        nxtClass  = CLS_NONE;
        nxtCount  = '0;
        nxtFired  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candActive <= 1'b0;
      candClass  <= CLS_NONE;
      runCount   <= '0;
      fired      <= 1'b0;
      primValid  <= 1'b0;
    end else begin
      candActive <= nxtActive;
      candClass  <= nxtClass;
      runCount   <= nxtCount;
      fired      <= nxtFired;
      primValid  <= stb.fire;
    end
  end

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!primValid && $stable(runCount))); // R10

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && candActive && matchCand && fired) |=> !primValid); // R9

  AST_FILLER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fillHold) |=> (!primValid && $stable(runCount) && candActive)); // R6

  AST_DATA_BREAKS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isPrim) |=> (!primValid && !candActive)); // R8

endmodule

// File: rtl/prim_seq_detect.sv
module prim_seq_detect
  import pdt_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  parameter int REP_NEED  = 2,
  parameter int RED_NEED  = 3,
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [31:0]      cfgValue,
  input  logic [2:0]       cfgClass,
  input  logic             inValid,
  input  logic [31:0]      dwordIn,
  input  logic             ctrlIn,
  output logic             primValid,
  output logic [IDX_W-1:0] primCode
);

  runStrobe_t stb;
  logic       isPrim;
  primClass_t hitClass;
  logic       matchCand;

  pdt_datapath #(.TBL_DEPTH(TBL_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgIdx    (cfgIdx),
    .cfgValue  (cfgValue),
    .cfgClass  (cfgClass),
    .dwordIn   (dwordIn),
    .ctrlIn    (ctrlIn),
    .stb       (stb),
    .isPrim    (isPrim),
    .hitClass  (hitClass),
    .matchCand (matchCand),
    .primCode  (primCode)
  );

  pdt_control #(.REP_NEED(REP_NEED), .RED_NEED(RED_NEED)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .isPrim    (isPrim),
    .hitClass  (hitClass),
    .matchCand (matchCand),
    .stb       (stb),
    .primValid (primValid)
  );

endmodule

// File: tb/prim_seq_detect_bench.sv
module prim_seq_detect_bench;

  localparam int DEPTH = 8;
  localparam int IW    = 3;
  localparam int REPN  = 2;
  localparam int REDN  = 3;

  localparam logic [31:0] V_SGL = 32'hA1B2C3BC;
  localparam logic [31:0] V_REP = 32'h4A4A5ABC;
  localparam logic [31:0] V_TRI = 32'h10203CBC;
  localparam logic [31:0] V_RED = 32'h777777BC;
  localparam logic [31:0] V_ALN = 32'h7B4A4ABC;
  localparam logic [31:0] V_NTF = 32'h1F1F1FBC;
  localparam logic [31:0] V_ERR = 32'h00AB00DC;
  localparam logic [31:0] V_STP = 32'h5555B57C;

  logic          clk = 0;
  logic          rstN = 0;
  logic          cfgWe = 0;
  logic [IW-1:0] cfgIdx = '0;
  logic [31:0]   cfgValue = '0;
  logic [2:0]    cfgClass = '0;
  logic          inValid = 0;
  logic [31:0]   dwordIn = '0;
  logic          ctrlIn = 0;
  logic          primValid;
  logic [IW-1:0] primCode;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] tVal [DEPTH];
  logic [2:0]  tCls [DEPTH];

  // reference run state
  logic        mActive = 0;
  logic [31:0] mCand   = '0;
  logic [2:0]  mClass  = '0;
  int          mCount  = 0;
  logic        mFired  = 0;
  logic        eValid  = 0;
  logic [IW-1:0] eCode = '0;

  always #4 clk = ~clk;  // 125 MHz

  prim_seq_detect #(.TBL_DEPTH(DEPTH), .REP_NEED(REPN), .RED_NEED(REDN)) u_prim_seq_detect (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValue(cfgValue),
    .cfgClass(cfgClass), .inValid(inValid), .dwordIn(dwordIn), .ctrlIn(ctrlIn),
    .primValid(primValid), .primCode(primCode)
  );

  function automatic int need(logic [2:0] c);
    case (c)
      3'd1: return 1;
      3'd2: return REPN;
      3'd3: return 3;
      3'd4: return REDN;
      default: return 99;
    endcase
  endfunction

  // index of matching entry, -1 if the dword is not a primitive (R2, R3)
  function automatic int lookup(logic [31:0] d, logic c);
    if (!c) return -1;
    if (d[7:0] != 8'hBC && d[7:0] != 8'h7C && d[7:0] != 8'hDC) return -1;
    for (int i = 0; i < DEPTH; i++)
      if (tVal[i] == d && tCls[i] >= 3'd1 && tCls[i] <= 3'd6) return i;
    return -1;
  endfunction

  task automatic modelStep(input logic [31:0] d, input logic c, input logic v);
    int idx;
    logic [2:0] cls;
    eValid = 0;
    if (!v) return;
    idx = lookup(d, c);
    cls = (idx >= 0) ? tCls[idx] : 3'd0;
    if (mActive && idx >= 0 && d == mCand) begin
      mCount++;
      if (!mFired && mCount >= need(mClass)) begin
        eValid = 1; mFired = 1; eCode = IW'(idx);
      end
    end else if (mActive && idx >= 0 &&
                 ((cls == 3'd5 && (mClass == 3'd3 || mClass == 3'd4)) ||
                  (cls == 3'd6 && mClass == 3'd3))) begin
      // tolerated filler
    end else if (idx >= 0 && cls >= 3'd1 && cls <= 3'd4) begin
      mActive = 1; mCand = d; mClass = cls; mCount = 1; mFired = 0;
      if (need(cls) == 1) begin
        eValid = 1; mFired = 1; eCode = IW'(idx);
      end
    end else begin
      mActive = 0; mCount = 0; mFired = 0;
    end
  endtask

  task automatic check(input logic act, input logic exp, input string what, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called just after a falling edge
  task automatic step(input logic [31:0] d, input logic c, input logic v, input string tag);
    dwordIn = d; ctrlIn = c; inValid = v;
    modelStep(d, c, v);
    @(negedge clk);
    nChecks++;
    if (primValid !== eValid || primCode !== eCode) begin
      nFails++;
      $display("FAIL %s: actual valid=%0d code=%0d expected valid=%0d code=%0d",
               tag, primValid, primCode, eValid, eCode);
    end
  endtask

  task automatic cfgWrite(input int idx, input logic [31:0] val, input logic [2:0] cls);
    cfgWe = 1; cfgIdx = IW'(idx); cfgValue = val; cfgClass = cls;
    @(negedge clk);
    cfgWe = 0;
    tVal[idx] = val; tCls[idx] = cls;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    logic [31:0] lastD;
    logic        lastC;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin tVal[i] = '0; tCls[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(primValid, 1'b0, "reset valid", "R1");
    nChecks++;
    if (primCode !== '0) begin
      nFails++;
      $display("FAIL R1 reset code: actual %0d expected 0", primCode);
    end

    cfgWrite(0, V_SGL, 3'd1);
    cfgWrite(1, V_REP, 3'd2);
    cfgWrite(2, V_TRI, 3'd3);
    cfgWrite(3, V_RED, 3'd4);
    cfgWrite(4, V_ALN, 3'd5);
    cfgWrite(5, V_NTF, 3'd6);
    cfgWrite(6, V_ERR, 3'd1);
    cfgWrite(7, V_SGL, 3'd3);   // duplicate: index 0 must win (R3)

    // R4 single, R3 priority, R9 no refire
    step(V_SGL, 1, 1, "R4 single first instance");
    step(V_SGL, 1, 1, "R9 no second pulse");
    step(32'h00000000, 0, 1, "R8 data breaks");
    step(V_SGL, 1, 1, "R9 rearmed after break");
    // R2 control flag required
    step(32'hDEADBEEF, 0, 1, "R8 data");
    step(V_SGL, 0, 1, "R2 no control flag");
    step(32'h123456A5, 1, 1, "R2 bad first character");
    cfgWrite(7, V_STP, 3'd3);   // R3 rewrite
    // R5 repeated
    step(V_REP, 1, 1, "R5 first");
    step(V_REP, 1, 1, "R5 threshold");
    step(V_REP, 1, 1, "R9 repeated continuing");
    step(V_REP, 1, 0, "R10 gap");
    step(V_ALN, 1, 1, "R5 filler breaks");
    step(V_REP, 1, 1, "R5 restart");
    step(V_ALN, 1, 1, "R5 filler breaks again");
    step(V_REP, 1, 1, "R5 restart no pulse");
    // R6 triple with fillers
    step(V_TRI, 1, 1, "R6 one");
    step(V_ALN, 1, 1, "R6 align held");
    step(V_NTF, 1, 1, "R6 notify held");
    step(V_TRI, 1, 1, "R6 two");
    step(V_ALN, 1, 1, "R6 align held");
    step(V_TRI, 1, 1, "R6 three pulses");
    step(V_TRI, 1, 1, "R9 triple continuing");
    // R7 redundant
    step(32'h0, 0, 1, "R8 data");
    step(V_RED, 1, 1, "R7 one");
    step(V_ALN, 1, 1, "R7 align held");
    step(V_RED, 1, 1, "R7 two");
    step(V_RED, 1, 1, "R7 three pulses");
    step(V_RED, 1, 1, "R9 redundant continuing");
    step(32'h0, 0, 1, "R8 data");
    step(V_RED, 1, 1, "R7 one");
    step(V_NTF, 1, 1, "R7 notify breaks");
    step(V_RED, 1, 1, "R7 restart one");
    step(V_RED, 1, 1, "R7 restart two no pulse");
    // R10 gaps inside a triple run
    step(32'h0, 0, 1, "R8 data");
    step(V_TRI, 1, 1, "R10 one");
    step(V_TRI, 1, 0, "R10 gap");
    step(V_TRI, 1, 1, "R10 two");
    step(V_TRI, 1, 0, "R10 gap");
    step(V_TRI, 1, 0, "R10 gap");
    step(V_TRI, 1, 1, "R10 three pulses");
    // R8 different primitive restarts
    step(32'h0, 0, 1, "R8 data");
    step(V_TRI, 1, 1, "R8 one");
    step(V_TRI, 1, 1, "R8 two");
    step(V_REP, 1, 1, "R8 other primitive");
    step(V_TRI, 1, 1, "R8 restart no pulse");
    // other lead characters, R11 code
    step(V_ERR, 1, 1, "R11 error single code");
    step(V_STP, 1, 1, "R11 sata one");
    step(V_STP, 1, 1, "R11 sata two");
    step(V_STP, 1, 1, "R11 sata three code");
    step(V_STP, 1, 0, "R11 code held");

    // constrained random
    pool[0] = V_SGL; pool[1] = V_REP; pool[2] = V_TRI; pool[3] = V_RED;
    pool[4] = V_ALN; pool[5] = V_NTF; pool[6] = V_ERR; pool[7] = V_STP;
    lastD = V_TRI; lastC = 1;
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [31:0] d;
      logic c, v;
      r = int'($urandom % 20);
      v = 1;
      if (r < 7) begin d = pool[$urandom % 8]; c = 1; end
      else if (r < 14) begin d = lastD; c = lastC; end
      else if (r < 16) begin d = $urandom; c = 0; end
      else if (r < 17) begin d = {$urandom % 32'h01000000, 8'hBC} ^ 32'h00010000; c = 1; end
      else if (r < 18) begin d = pool[$urandom % 8]; c = 0; end
      else begin d = lastD; c = lastC; v = 0; end
      if (r < 14 && d != V_ALN && d != V_NTF) begin lastD = d; lastC = c; end
      step(d, c, v, "R8 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule